// File: doc/BRIEF.md
# Translation Unit Control and Status Registers

This block is the software-facing front of a paged address-translation unit. It holds the translation directory base, the paging and stall state, the page-fault state, and the interrupt state. Software drives it through a 32-bit register port. It starts actions by writing numeric command codes to a single write-only command register.

Paging and stall changes are not immediate. Each one completes a fixed number of cycles (`LAT`, default 4) after its command is written, so software polls the status register until the bit moves. The translation engine reports fault events and bus errors on dedicated inputs. Raw interrupt bits are gated by a mask and ORed into one interrupt line. Actual translation, table walks and stalling of real traffic lie outside this block.

The offsets software uses are: 0x00 directory base, 0x04 status, 0x08 command, 0x0C fault address, 0x10 invalidate-one-line (write-only, no effect here), 0x14 raw interrupt, 0x18 interrupt clear, 0x1C interrupt mask, 0x20 masked interrupt, 0x24 clock-gating control.

Top module: `xlt_csr`

## Requirements
- R1: The directory base at 0x00 keeps only bits [31:12], and bits [11:0] read as zero; writing 0xCAFEBABE reads back 0xCAFEB000.
- R2: Command code 6 (force reset) sets the directory base to 0x00000000. It also clears the paging, stall and fault-active state on the next clock edge.
- R3: Command 0 sets status bit0 (paging on) and command 1 clears it. The change becomes visible exactly `LAT` clock edges after the edge that writes the command, and not earlier.
- R4: Command 2 sets status bit2 (stall active) and command 3 clears it, with the same `LAT` latency. Command 2 is ignored while paging is off.
- R5: Status bit31 always reads as the inverse of status bit2.
- R6: A fault event (`flt_valid`) with no fault active has three effects. It latches `flt_addr` into 0x0C, and it sets status bit1. It also records `flt_write` in status bit5. A fault event while a fault is already active leaves 0x0C unchanged.
- R7: Command 5 (fault handled) clears status bit1, so that the next fault event latches a new address.
- R8: Raw interrupt 0x14 bit0 is set by a fault event and bit1 is set by `bus_err`; both bits stay set until cleared.
- R9: Writing 0x18 clears each raw interrupt bit whose data bit is 1 and leaves the other raw bits unchanged.
- R10: Masked interrupt 0x20 equals raw 0x14 AND mask 0x1C (2 bits), and `irq` is high exactly when 0x20 is nonzero.
- R11: Command 4 and command codes above 6 change no readable state. Register 0x24 is plain 32-bit read/write storage with no side effects, and 0x10 reads zero.
- R12: After reset, status reads 0x80000018 (bit31, bit4 and bit3 set). The directory base, mask, raw interrupt, fault address and 0x24 all read zero.
- R13: Status bit3 (idle) is low while a paging or stall change is pending or a fault is active. Status bit4 (replay empty) is low while a fault is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | ADDR_W | Register read byte offset |
| rd_data | output | 32 | Combinational read data |
| flt_valid | input | 1 | One-cycle fault event from the translation engine |
| flt_addr | input | 32 | Faulting virtual address |
| flt_write | input | 1 | Faulting access was a write |
| bus_err | input | 1 | One-cycle bus error event |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a second fault that arrives while a first is still outstanding, combined with a bus error and partial clears. The stimulus raises a fault, raises a different fault before issuing command 5, and confirms that the held address does not move. It then adds a bus error, walks the mask and clear registers one bit at a time, and finally issues command 5 so that a third fault can latch. Transition latency is checked by polling status on the edge just before and the edge of the expected change.

// File: rtl/xlt_csr.sv
module xlt_csr #(
  parameter int ADDR_W = 8,
  parameter int LAT    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  input  logic              flt_valid,
  input  logic [31:0]       flt_addr,
  input  logic              flt_write,
  input  logic              bus_err,
  output logic              irq
);
  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;
  localparam logic [CW-1:0] CNT_LOAD = CW'(LAT - 1);

  logic [19:0]   base_q;
  logic          paging_q, stall_q, fault_q, fwr_q;
  logic [31:0]   fa_q, gate_q;
  logic [1:0]    raw_q, mask_q;
  logic          pend_q;
  logic [1:0]    tgt_q;
  logic [CW-1:0] cnt_q;

  wire        cmd_we = wr_en && (wr_addr == ADDR_W'(8'h08));
  wire [1:0]  masked = raw_q & mask_q;
  wire [1:0]  clr    = (wr_en && wr_addr == ADDR_W'(8'h18)) ? wr_data[1:0] : 2'b00;
  wire        idle   = !pend_q && !fault_q;
  wire [31:0] status = {~stall_q, 25'b0, fault_q & fwr_q, ~fault_q, idle, stall_q, fault_q, paging_q};

  assign irq = |masked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q   <= '0;
      paging_q <= 1'b0;
      stall_q  <= 1'b0;
      fault_q  <= 1'b0;
      fwr_q    <= 1'b0;
      fa_q     <= '0;
      gate_q   <= '0;
      raw_q    <= '0;
      mask_q   <= '0;
      pend_q   <= 1'b0;
      tgt_q    <= '0;
      cnt_q    <= '0;
    end else begin
      if (pend_q) begin
        if (cnt_q == '0) begin
          pend_q <= 1'b0;
          case (tgt_q)
            2'd0: paging_q <= 1'b1;
            2'd1: paging_q <= 1'b0;
            2'd2: stall_q  <= 1'b1;
            default: stall_q <= 1'b0;
          endcase
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end

      if (flt_valid && !fault_q) begin
        fault_q <= 1'b1;
        fa_q    <= flt_addr;
        fwr_q   <= flt_write;
      end

      if (cmd_we) begin
        case (wr_data)
          32'd0, 32'd1, 32'd3: begin
            pend_q <= 1'b1;
            tgt_q  <= wr_data[1:0];
            cnt_q  <= CNT_LOAD;
          end
          32'd2: if (paging_q) begin
            pend_q <= 1'b1;
            tgt_q  <= 2'd2;
            cnt_q  <= CNT_LOAD;
          end
          32'd5: fault_q <= 1'b0;
          32'd6: begin
            base_q   <= '0;
            paging_q <= 1'b0;
            stall_q  <= 1'b0;
            fault_q  <= 1'b0;
            pend_q   <= 1'b0;
          end
          default: ;
        endcase
      end

      if (wr_en) begin
        case (wr_addr)
          ADDR_W'(8'h00): base_q <= wr_data[31:12];
          ADDR_W'(8'h1C): mask_q <= wr_data[1:0];
          ADDR_W'(8'h24): gate_q <= wr_data;
          default: ;
        endcase
      end

      raw_q <= (raw_q & ~clr) | {bus_err, flt_valid};
    end
  end

  always_comb begin
    case (rd_addr)
      ADDR_W'(8'h00): rd_data = {base_q, 12'b0};
      ADDR_W'(8'h04): rd_data = status;
      ADDR_W'(8'h0C): rd_data = fa_q;
      ADDR_W'(8'h14): rd_data = {30'b0, raw_q};
      ADDR_W'(8'h1C): rd_data = {30'b0, mask_q};
      ADDR_W'(8'h20): rd_data = {30'b0, masked};
      ADDR_W'(8'h24): rd_data = gate_q;
      default:        rd_data = '0;
    endcase
  end
endmodule

// File: rtl/xlt_csr_chk.sv
module xlt_csr_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic              flt_valid,
  input logic              irq,
  input logic [19:0]       base_q,
  input logic              paging_q,
  input logic              stall_q,
  input logic              fault_q,
  input logic [31:0]       fa_q,
  input logic [1:0]        raw_q,
  input logic [1:0]        mask_q
);
  wire is_cmd = wr_en && wr_addr == ADDR_W'(8'h08);

  assert_base_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(8'h00)) |=> (base_q == $past(wr_data[31:12])));

  assert_force_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cmd && wr_data == 32'd6) |=> (base_q == 20'd0 && !paging_q && !stall_q && !fault_q));

  assert_stall_needs_paging_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall_q) |-> $past(paging_q));

  assert_fault_addr_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && !(is_cmd && (wr_data == 32'd5 || wr_data == 32'd6))) |=> $stable(fa_q));

  assert_clear_bit0_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(8'h18) && wr_data[0] && !flt_valid) |=> !raw_q[0]);

  assert_irq_needs_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_q != 2'b00 && raw_q != 2'b00));
endmodule

bind xlt_csr xlt_csr_chk #(.ADDR_W(ADDR_W)) chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .flt_valid(flt_valid), .irq(irq), .base_q(base_q), .paging_q(paging_q),
  .stall_q(stall_q), .fault_q(fault_q), .fa_q(fa_q), .raw_q(raw_q), .mask_q(mask_q)
);

// File: tb/tb_xlt_csr.sv
module tb_xlt_csr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        flt_valid = 1'b0;
  logic [31:0] flt_addr = '0;
  logic        flt_write = 1'b0;
  logic        bus_err = 1'b0;
  logic        irq;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  xlt_csr dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .flt_valid(flt_valid), .flt_addr(flt_addr),
    .flt_write(flt_write), .bus_err(bus_err), .irq(irq));

  // {is_write, offset, data or expected}
  localparam logic [40:0] TBL [12] = '{
    {1'b1, 8'h00, 32'hCAFEBABE}, {1'b0, 8'h00, 32'hCAFEB000},   // R1
    {1'b1, 8'h24, 32'h12345678}, {1'b0, 8'h24, 32'h12345678},   // R11
    {1'b1, 8'h10, 32'hFFFFFFFF}, {1'b0, 8'h10, 32'h00000000},   // R11
    {1'b1, 8'h08, 32'h00000007}, {1'b0, 8'h04, 32'h80000018},   // R11
    {1'b1, 8'h08, 32'h00000004}, {1'b0, 8'h04, 32'h80000018},   // R11
    {1'b0, 8'h00, 32'hCAFEB000}, {1'b0, 8'h14, 32'h00000000}    // R11
  };

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    rd_addr = a; #1;
    n_chk++;
    if (rd_data !== exp) begin
      n_bad++;
      $display("FAIL %s off=%h actual=%h expected=%h", tag, a, rd_data, exp);
    end
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    n_chk++;
    if (irq !== exp) begin
      n_bad++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq, exp);
    end
  endtask

  task automatic fault(input logic [31:0] a, input logic w);
    @(negedge clk); flt_valid = 1'b1; flt_addr = a; flt_write = w;
    @(negedge clk); flt_valid = 1'b0;
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(8'h04, 32'h80000018, "R12 status");
    chk(8'h00, 32'h0, "R12 base");
    chk(8'h1C, 32'h0, "R12 mask");
    chk(8'h0C, 32'h0, "R12 fault addr");
    chk(8'h24, 32'h0, "R12 gating");
    chk_irq(1'b0, "R12");

    for (int i = 0; i < 12; i++) begin
      if (TBL[i][40]) wr(TBL[i][39:32], TBL[i][31:0]);
      else chk(TBL[i][39:32], TBL[i][31:0], $sformatf("R1/R11 table vec %0d", i));
    end

    wr(8'h08, 32'd2);
    idle_cycles(6);
    chk(8'h04, 32'h80000018, "R4 stall ignored while paging off");

    wr(8'h08, 32'd0);
    chk(8'h04, 32'h80000010, "R13 idle low while pending");
    idle_cycles(3);
    chk(8'h04, 32'h80000010, "R3 paging not yet on");
    idle_cycles(1);
    chk(8'h04, 32'h80000019, "R3 paging on after LAT");

    wr(8'h08, 32'd2);
    idle_cycles(3);
    chk(8'h04, 32'h80000011, "R4 stall not yet");
    idle_cycles(1);
    chk(8'h04, 32'h0000001D, "R4/R5 stall on, bit31 low");
    wr(8'h08, 32'd3);
    idle_cycles(4);
    chk(8'h04, 32'h80000019, "R4/R5 stall off, bit31 high");

    wr(8'h1C, 32'd3);
    fault(32'h00ABC123, 1'b1);
    chk(8'h0C, 32'h00ABC123, "R6 fault addr latched");
    chk(8'h04, 32'h80000023, "R6/R13 fault status");
    chk(8'h14, 32'h1, "R8 raw fault");
    chk(8'h20, 32'h1, "R10 masked");
    chk_irq(1'b1, "R10");
    fault(32'h00000555, 1'b0);
    chk(8'h0C, 32'h00ABC123, "R6 address held");
    @(negedge clk); bus_err = 1'b1; @(negedge clk); bus_err = 1'b0;
    chk(8'h14, 32'h3, "R8 raw bus error");
    wr(8'h1C, 32'd2);
    chk(8'h20, 32'h2, "R10 mask bus only");
    chk_irq(1'b1, "R10 bus only");
    wr(8'h1C, 32'd0);
    chk(8'h20, 32'h0, "R10 masked zero");
    chk_irq(1'b0, "R10 masked off");
    wr(8'h18, 32'd1);
    chk(8'h14, 32'h2, "R9 clear bit0 only");
    wr(8'h18, 32'd2);
    chk(8'h14, 32'h0, "R9 clear bit1");

    wr(8'h08, 32'd5);
    chk(8'h04, 32'h80000019, "R7 fault cleared");
    fault(32'h00000777, 1'b0);
    chk(8'h0C, 32'h00000777, "R7 new fault latched");
    chk(8'h04, 32'h80000003, "R6 read fault flag");
    wr(8'h08, 32'd5);

    wr(8'h00, 32'hFFFFF000);
    wr(8'h08, 32'd6);
    chk(8'h00, 32'h0, "R2 base cleared");
    chk(8'h04, 32'h80000018, "R2 state cleared");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule